// File: doc/BRIEF.md
# Decimate-by-Three Polyphase FIR Filter

This block is a nine-tap low-pass FIR filter that also reduces the sample rate by three. It accepts at most one signed sample per clock, qualified by a valid strobe, and emits one filtered result for every three accepted samples. It computes only the results that survive decimation. Each incoming sample is multiplied in the same cycle by three coefficients whose indices are spaced three apart. The products are folded into a chain of three running partial sums, in transposed form, so the input needs no delay line.

A phase counter tracks the position of the current sample within its group of three, and it picks which coefficient triple is applied. On the first phase of each group the oldest partial sum completes, is registered as the output, and the chain moves one stage toward the output. The coefficients are a parameter array. When the tap count is not a multiple of three, the coefficient set is extended with zeros. The block is a drop-in stage inside a larger sample-rate conversion path.

Top module: `poly_decim_fir`

## Requirements
- R1: A synchronous active-high `rst` clears the output strobe, the output value, every partial sum and the phase count. After reset, `out_valid` is 0, `out_data` is 0, and the next results depend only on samples accepted after reset.
- R2: Accepted samples are numbered n = 0, 1, 2, … from reset. `out_valid` is 1 for exactly the one cycle that follows the clock edge accepting a sample with n mod 3 = 0, and it is 0 in every other cycle.
- R3: The value presented with the m-th pulse (m from 0) is the signed sum over k = 0..8 of h(k)·x(3m−k), where x(i) = 0 for i < 0. Input and coefficients are two's complement.
- R4: A cycle with `in_valid` low changes nothing. The value on `in_data` is ignored, the sample numbering does not advance, and no pulse follows.
- R5: `out_data` holds the most recent result, unchanged, in every cycle without a pulse.
- R6: With 8-bit inputs and 8-bit coefficients, the 20-bit result is exact for any input sequence, including runs at −128 and +127.
- R7: With a tap count that is not a multiple of three, the block behaves as if the coefficient list were extended with zeros to the next multiple of three. For example, 7 taps behave as 9 taps with h(7) = h(8) = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies `in_data` in this cycle |
| in_data | input | DATA_W (8) | Two's complement input sample |
| out_valid | output | 1 | One-cycle strobe marking a new decimated result |
| out_data | output | ACC_W (20) | Two's complement filtered, decimated result |

## Verification
The result for a sample with index n mod 3 = 0 is registered on the same rising edge that accepts that sample. Both `out_valid` and the new `out_data` are therefore due one register after acceptance, with no further pipeline. The bench drives inputs on the falling edge, then samples both outputs shortly after the following rising edge. It compares them every cycle against a model that keeps the full input history and evaluates the nine-tap convolution at each kept index. Idle cycles are checked in the same slot: no pulse, and the previous value held.

// File: rtl/poly_decim_pkg.sv
package poly_decim_pkg;

    // Integer ceiling division used for stage counts.
    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    // Bits needed to count 0..n-1 (at least one bit).
    function automatic int count_bits(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/pdf_phase_ctr.sv
module pdf_phase_ctr #(
    parameter int DECIM = 3,
    parameter int PH_W  = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            adv,
    output logic [PH_W-1:0] phase
);
    localparam logic [PH_W-1:0] LAST = PH_W'(DECIM - 1);

    logic [PH_W-1:0] phase_d, phase_q;

    always_comb begin
        phase_d = phase_q;
        if (adv) begin
            phase_d = (phase_q == LAST) ? '0 : phase_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) phase_q <= '0;
        else     phase_q <= phase_d;
    end

    assign phase = phase_q;
endmodule

// File: rtl/pdf_coef_sel.sv
module pdf_coef_sel #(
    parameter int COEF_W = 8,
    parameter int TAPS   = 9,
    parameter int DECIM  = 3,
    parameter int STAGES = 3,
    parameter int PH_W   = 2,
    parameter logic signed [COEF_W-1:0] COEFS [TAPS] = '{default: '0}
) (
    input  logic        [PH_W-1:0]   phase,
    output logic signed [COEF_W-1:0] coef [STAGES]
);
    // Zero beyond the real taps: pads the set to STAGES*DECIM entries.
    function automatic logic signed [COEF_W-1:0] padded(input int idx);
        if (idx < TAPS) return COEFS[idx];
        return '0;
    endfunction

    logic [PH_W-1:0] first_idx;

    always_comb begin
        // Phase p contributes at distance (DECIM - p) mod DECIM from the kept index.
        first_idx = (phase == '0) ? '0 : PH_W'(DECIM) - phase;
        for (int s = 0; s < STAGES; s++) begin
            coef[s] = '0;
            for (int r = 0; r < DECIM; r++) begin
                if (first_idx == PH_W'(r)) coef[s] = padded(r + s * DECIM);
            end
        end
    end
endmodule

// File: rtl/pdf_tap_mul.sv
module pdf_tap_mul #(
    parameter int DATA_W = 8,
    parameter int COEF_W = 8
) (
    input  logic signed [DATA_W-1:0]        sample,
    input  logic signed [COEF_W-1:0]        coef,
    output logic signed [DATA_W+COEF_W-1:0] prod
);
    assign prod = sample * coef;
endmodule

// File: rtl/poly_decim_fir.sv
module poly_decim_fir
    import poly_decim_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int COEF_W = 8,
    parameter int ACC_W  = 20,
    parameter int TAPS   = 9,
    parameter int DECIM  = 3,
    parameter logic signed [COEF_W-1:0] COEFS [TAPS] =
        '{-8'sd5, 8'sd12, -8'sd128, 8'sd34, 8'sd127, 8'sd41, 8'sd9, -8'sd17, 8'sd3}
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [ACC_W-1:0]  out_data
);
    localparam int STAGES = ceil_div(TAPS, DECIM);
    localparam int PH_W   = count_bits(DECIM);
    localparam int PROD_W = DATA_W + COEF_W;

    typedef struct packed {
        logic [STAGES-1:0][ACC_W-1:0] acc;   // acc[0] completes first
        logic [ACC_W-1:0]             dout;
        logic                         vld;
    } state_t;

    state_t st_d, st_q;

    logic        [PH_W-1:0]   phase;
    logic signed [COEF_W-1:0] coef [STAGES];
    logic signed [PROD_W-1:0] prod [STAGES];

    pdf_phase_ctr #(.DECIM(DECIM), .PH_W(PH_W)) u_phase (
        .clk   (clk),
        .rst   (rst),
        .adv   (in_valid),
        .phase (phase)
    );

    pdf_coef_sel #(
        .COEF_W(COEF_W), .TAPS(TAPS), .DECIM(DECIM),
        .STAGES(STAGES), .PH_W(PH_W), .COEFS(COEFS)
    ) u_coef (
        .phase (phase),
        .coef  (coef)
    );

    for (genvar g = 0; g < STAGES; g++) begin : g_mul
        pdf_tap_mul #(.DATA_W(DATA_W), .COEF_W(COEF_W)) u_mul (
            .sample ($signed(in_data)),
            .coef   (coef[g]),
            .prod   (prod[g])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (in_valid) begin
            if (phase == '0) begin
                // Kept index: finish the oldest sum and shift the chain.
                st_d.dout = st_q.acc[0] + ACC_W'(prod[0]);
                st_d.vld  = 1'b1;
                for (int s = 0; s < STAGES - 1; s++) begin
                    st_d.acc[s] = st_q.acc[s+1] + ACC_W'(prod[s+1]);
                end
                st_d.acc[STAGES-1] = '0;
            end else begin
                for (int s = 0; s < STAGES; s++) begin
                    st_d.acc[s] = st_q.acc[s] + ACC_W'(prod[s]);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_data  = st_q.dout;
endmodule

// File: rtl/poly_decim_fir_chk.sv
module poly_decim_fir_chk #(
    parameter int DATA_W = 8,
    parameter int COEF_W = 8,
    parameter int ACC_W  = 20,
    parameter int TAPS   = 9,
    parameter int DECIM  = 3,
    parameter logic signed [COEF_W-1:0] COEFS [TAPS] = '{default: '0}
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              out_valid,
    input logic [ACC_W-1:0]  out_data
);
    function automatic longint abs_sum();
        longint t = 0;
        for (int i = 0; i < TAPS; i++) begin
            t += (COEFS[i] < 0) ? -longint'(COEFS[i]) : longint'(COEFS[i]);
        end
        return t;
    endfunction

    localparam longint LIMIT = abs_sum() * (longint'(1) << (DATA_W - 1));

    // Independent count of accepted samples modulo DECIM.
    int   cnt_q;
    logic due_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= 0;
            due_q <= 1'b0;
        end else begin
            due_q <= in_valid && (cnt_q == 0);
            if (in_valid) cnt_q <= (cnt_q == DECIM - 1) ? 0 : cnt_q + 1;
        end
    end

    // R1: reset leaves a quiet, zeroed output
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!out_valid && out_data == '0));

    // R2: strobe follows exactly the kept sample indices
    p_pulse_phase_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid == due_q);

    // R2: strobe lasts one cycle
    p_single_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R4: an idle cycle is never followed by a strobe
    p_idle_no_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R5: output value held between strobes
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_data));

    // R6: result stays inside the reachable signed range
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (longint'($signed(out_data)) <= LIMIT &&
                       longint'($signed(out_data)) >= -LIMIT));
endmodule

bind poly_decim_fir poly_decim_fir_chk #(
    .DATA_W(DATA_W), .COEF_W(COEF_W), .ACC_W(ACC_W),
    .TAPS(TAPS), .DECIM(DECIM), .COEFS(COEFS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/poly_decim_fir_test.sv
module poly_decim_fir_test;
    localparam int CLK_PERIOD = 10;
    localparam logic signed [7:0] C9 [9] =
        '{-8'sd5, 8'sd12, -8'sd128, 8'sd34, 8'sd127, 8'sd41, 8'sd9, -8'sd17, 8'sd3};
    localparam logic signed [7:0] C7 [7] =
        '{8'sd11, -8'sd7, 8'sd23, -8'sd128, 8'sd64, 8'sd5, -8'sd2};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        out_valid, pad_valid;
    logic [19:0] out_data, pad_data;

    int total = 0;
    int fails = 0;
    int hist [0:1023];
    int n = 0;
    int last9 = 0;
    int lastp = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    poly_decim_fir #(.TAPS(9), .COEFS(C9)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    poly_decim_fir #(.TAPS(7), .COEFS(C7)) uut_pad (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .out_valid(pad_valid), .out_data(pad_data)
    );

    function automatic int ref_y(int m, bit pad);
        int s = 0;
        for (int k = 0; k < 9; k++) begin
            int idx = 3 * m - k;
            int c = pad ? ((k < 7) ? int'(C7[k]) : 0) : int'(C9[k]);
            if (idx >= 0) s += c * hist[idx];
        end
        return s;
    endfunction

    task automatic check(string req, string what, int act, int exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One clock: drive on the falling edge, sample after the rising edge.
    task automatic step(bit v, logic [7:0] d, string tag);
        bit exp_v = 1'b0;
        @(negedge clk);
        in_valid = v;
        in_data  = d;
        @(posedge clk);
        #1;
        if (v) begin
            hist[n] = int'($signed(d));
            if (n % 3 == 0) begin
                exp_v = 1'b1;
                last9 = ref_y(n / 3, 1'b0);
                lastp = ref_y(n / 3, 1'b1);
            end
            n++;
        end
        check(v ? "R2" : "R4", "out_valid", int'(out_valid), int'(exp_v));
        check(exp_v ? tag : "R5", "out_data", int'($signed(out_data)), last9);
        check("R7", "pad out_valid", int'(pad_valid), int'(exp_v));
        check("R7", "pad out_data", int'($signed(pad_data)), lastp);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R1", "out_valid in reset", int'(out_valid), 0);
        check("R1", "out_data in reset", int'($signed(out_data)), 0);
        check("R1", "pad out_data in reset", int'($signed(pad_data)), 0);
        @(negedge clk);
        rst = 1'b0;
        n = 0; last9 = 0; lastp = 0;
    endtask

    // Impulse at each phase exposes every coefficient in order (R3).
    task automatic t_impulse(int offset);
        for (int i = 0; i < offset; i++) step(1'b1, 8'd0, "R3");
        step(1'b1, 8'd100, "R3");
        for (int i = 0; i < 12; i++) step(1'b1, 8'd0, "R3");
    endtask

    // Idle cycles with junk data between accepted samples (R4, R5).
    task automatic t_gaps();
        for (int i = 0; i < 24; i++) begin
            step(1'b1, 8'(i * 13 - 40), "R3");
            step(1'b0, 8'hA5, "R4");
            if (i % 4 == 0) step(1'b0, 8'h80, "R4");
        end
    endtask

    // Full-scale runs at both ends of the input range (R6).
    task automatic t_extremes();
        for (int i = 0; i < 18; i++) step(1'b1, 8'h80, "R6");
        for (int i = 0; i < 18; i++) step(1'b1, 8'h7F, "R6");
        for (int i = 0; i < 18; i++) step(1'b1, (C9[i % 9] < 0) ? 8'h7F : 8'h80, "R6");
    endtask

    // Partial sums pending, then reset: only later samples matter (R1).
    task automatic t_mid_reset();
        for (int i = 0; i < 7; i++) step(1'b1, 8'h7F, "R3");
        t_reset();
        step(1'b1, 8'd1, "R1");
        for (int i = 0; i < 9; i++) step(1'b1, 8'd0, "R1");
    endtask

    task automatic t_random();
        for (int i = 0; i < 300; i++) begin
            step(($urandom % 4) != 0, 8'($urandom), "R3");
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        total++;
        $display("FAIL R2 watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        t_reset();
        t_impulse(0);
        t_impulse(1);
        t_impulse(2);
        t_reset();
        t_gaps();
        t_reset();
        t_extremes();
        t_mid_reset();
        t_reset();
        t_random();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule